// File: doc/BRIEF.md
# Status Register Write Masking Unit

This block takes a software write aimed at the processor status word and turns it into a bit-level write enable. A 4-bit byte-select picks the regions the write may touch. Inside those regions, the writable bits depend on three things:

- whether the current mode is privileged;
- the security and permission context;
- whether the requested new mode passes a legality check.

The block holds the resulting status word in a register. It reports a dropped mode request as a one-cycle flag.

A second register holds a saved copy of the status word. It takes the same data and byte-select, and each select bit enables one whole field with no context gating. The two registers have separate write strobes, so exception logic, return paths and mode-switch writes can all drive the unit from one place.

Mode codes are five bits wide: user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, monitor 0x16, abort 0x17, hypervisor 0x1A, undefined 0x1B, system 0x1F. A code whose bit 4 is clear is a 64-bit mode and is never in the list. Privileged means the current mode is anything other than user.

Top module: `psr_wmask_unit`

## Requirements
- R1: A synchronous active-high reset sets the status word to 0x000001D3 (supervisor, bits 8, 7 and 6 set), the saved word to 0 and the flag to 0.
- R2: With byte-select bit 3, bits 31:24 are writable if affect-state is high, otherwise bits 31:27. With byte-select bit 2, bits 19:16 are writable. Bits 23:20 of the status word are never written.
- R3: With byte-select bit 1, bit 9 is writable, and bits 15:10 are writable only when affect-state is high.
- R4: Bit 8 is writable only with byte-select bit 1, a privileged current mode, and at least one of secure, abort-write permit or virtualization present.
- R5: With byte-select bit 0 and a privileged current mode, bit 7 is writable. From user mode, bits 7, 6 and 4:0 never change.
- R6: Bit 6 is writable only with byte-select bit 0 in a privileged mode, when (non-maskable-FIQ is low or written bit 6 is 0) and (secure or FIQ-write permit or virtualization present).
- R7: Bit 5 is writable whenever byte-select bit 0 and affect-state are both high, in any mode.
- R8: A privileged write with byte-select bit 0 updates bits 4:0 to the written mode when the mode request is accepted.
- R9: A mode request is rejected when a non-secure context asks for monitor mode, when a non-secure context asks for FIQ mode with the FIQ-bank restriction set, or when hypervisor mode is asked for with the non-secure bit at 0. The cycle after a rejected privileged byte-0 write, the flag is high for one cycle.
- R10: A written mode code outside the list (including every 64-bit code) is rejected and leaves the mode unchanged. It raises the flag like R9.
- R11: On a saved write, byte-select bits 3, 2, 1 and 0 update bits 31:24, 19:16, 15:8 and 7:0 of the saved word, with no context gating.
- R12: With the status write strobe low, the status word holds and the flag is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Status word write strobe |
| sv_wr_en | input | 1 | Saved word write strobe |
| wr_data | input | 32 | Write data for both words |
| byte_sel | input | 4 | Field select |
| affect_state | input | 1 | Widens the writable fields (R2, R3, R7) |
| sec_state | input | 1 | Current context is secure |
| aw_permit | input | 1 | Abort-mask write permit from non-secure |
| fw_permit | input | 1 | FIQ-mask write permit from non-secure |
| fiq_restrict | input | 1 | Forbids non-secure entry to FIQ mode |
| ns_bit | input | 1 | Non-secure bit of the security configuration |
| virt_present | input | 1 | Virtualization support present |
| nmfi | input | 1 | FIQ cannot be masked by software |
| status_o | output | 32 | Registered status word |
| saved_o | output | 32 | Registered saved word |
| illegal_o | output | 1 | One-cycle flag for a dropped mode request |

## Verification
Four starting modes are covered: user, FIQ, supervisor and hypervisor. For each, every byte-select value is crossed with both affect-state values and all 128 combinations of the seven context bits. The user-mode start separates privilege gating from byte selection. Twelve target mode codes rotate through the writes, including two 64-bit codes and one unused 32-bit code, so legal, context-rejected and badly encoded requests each drive the flag. Between writes, a strobe-low cycle with fresh data shows that the status word holds and that the flag is not sticky.

// File: rtl/psr_wmask_pkg.sv
package psr_wmask_pkg;
  localparam int PSR_W  = 32;
  localparam int MODE_W = 5;

  typedef logic [PSR_W-1:0]  psr_word_t;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t M_USR = 5'h10;
  localparam mode_t M_FIQ = 5'h11;
  localparam mode_t M_IRQ = 5'h12;
  localparam mode_t M_SVC = 5'h13;
  localparam mode_t M_MON = 5'h16;
  localparam mode_t M_ABT = 5'h17;
  localparam mode_t M_HYP = 5'h1A;
  localparam mode_t M_UND = 5'h1B;
  localparam mode_t M_SYS = 5'h1F;

  // supervisor with abort, IRQ and FIQ masked
  localparam psr_word_t RESET_WORD = 32'h0000_01D3;

  function automatic logic mode_known(input mode_t m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_MON, M_ABT, M_HYP, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_is64(input mode_t m);
    return ~m[MODE_W-1];
  endfunction
endpackage

// File: rtl/psr_mode_gate.sv
module psr_mode_gate
  import psr_wmask_pkg::*;
(
  input  mode_t old_mode,
  input  mode_t new_mode,
  input  logic  sec_state,
  input  logic  fiq_restrict,
  input  logic  ns_bit,
  output logic  mode_ok
);
  always_comb begin
    mode_ok = mode_known(new_mode);
    if (!sec_state && new_mode == M_MON)                 mode_ok = 1'b0;
    if (!sec_state && new_mode == M_FIQ && fiq_restrict) mode_ok = 1'b0;
    if (!ns_bit && new_mode == M_HYP)                    mode_ok = 1'b0;
    if (!mode_is64(old_mode) && mode_is64(new_mode))     mode_ok = 1'b0;
  end
endmodule

// File: rtl/psr_cur_mask.sv
module psr_cur_mask
  import psr_wmask_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] byte_sel,
  input  logic             affect_state,
  input  logic             privileged,
  input  logic             sec_state,
  input  logic             aw_permit,
  input  logic             fw_permit,
  input  logic             virt_present,
  input  logic             nmfi,
  input  logic             new_fiq_bit,
  input  logic             mode_ok,
  output psr_word_t        mask,
  output logic             mode_drop
);
  localparam int TOP_LO_AFF = 24;
  localparam int TOP_LO     = 27;
  localparam int MID_HI_AFF = 15;
  localparam int MID_HI     = 9;

  logic abt_open, fiq_open, mode_req;

  assign abt_open = privileged & (sec_state | aw_permit | virt_present);
  assign fiq_open = (~nmfi | ~new_fiq_bit) & (sec_state | fw_permit | virt_present);
  assign mode_req = byte_sel[0] & privileged;

  always_comb begin
    mask = '0;
    if (byte_sel[3]) begin
      for (int b = TOP_LO_AFF; b < PSR_W; b++)
        if (affect_state || b >= TOP_LO) mask[b] = 1'b1;
    end
    if (byte_sel[2]) mask[19:16] = 4'hF;
    if (byte_sel[1]) begin
      for (int b = MID_HI; b <= MID_HI_AFF; b++)
        if (affect_state || b <= MID_HI) mask[b] = 1'b1;
      if (abt_open) mask[8] = 1'b1;
    end
    if (byte_sel[0]) begin
      if (affect_state) mask[5] = 1'b1;
      if (privileged) begin
        mask[7] = 1'b1;
        if (fiq_open) mask[6] = 1'b1;
        if (mode_ok)  mask[MODE_W-1:0] = '1;
      end
    end
  end

  assign mode_drop = mode_req & ~mode_ok;
endmodule

// File: rtl/psr_saved_mask.sv
module psr_saved_mask
  import psr_wmask_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] byte_sel,
  output psr_word_t        mask
);
  function automatic int lane_lo(input int i);
    return (i == 2) ? 16 : i * 8;
  endfunction
  function automatic int lane_hi(input int i);
    return (i == 2) ? 19 : i * 8 + 7;
  endfunction

  assign mask[23:20] = '0;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = lane_hi(i);
    localparam int LO = lane_lo(i);
    assign mask[HI:LO] = {(HI - LO + 1){byte_sel[i]}};
  end
endmodule

// File: rtl/psr_wmask_unit.sv
module psr_wmask_unit
  import psr_wmask_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             sv_wr_en,
  input  logic [31:0]      wr_data,
  input  logic [SEL_W-1:0] byte_sel,
  input  logic             affect_state,
  input  logic             sec_state,
  input  logic             aw_permit,
  input  logic             fw_permit,
  input  logic             fiq_restrict,
  input  logic             ns_bit,
  input  logic             virt_present,
  input  logic             nmfi,
  output logic [31:0]      status_o,
  output logic [31:0]      saved_o,
  output logic             illegal_o
);
  psr_word_t status_q, saved_q, cur_mask, sv_mask;
  logic      illegal_q, privileged, mode_ok, mode_drop;

  assign privileged = (status_q[MODE_W-1:0] != M_USR);

  psr_mode_gate u_gate (
    .old_mode     (status_q[MODE_W-1:0]),
    .new_mode     (wr_data[MODE_W-1:0]),
    .sec_state    (sec_state),
    .fiq_restrict (fiq_restrict),
    .ns_bit       (ns_bit),
    .mode_ok      (mode_ok)
  );

  psr_cur_mask #(.SEL_W(SEL_W)) u_cmask (
    .byte_sel     (byte_sel),
    .affect_state (affect_state),
    .privileged   (privileged),
    .sec_state    (sec_state),
    .aw_permit    (aw_permit),
    .fw_permit    (fw_permit),
    .virt_present (virt_present),
    .nmfi         (nmfi),
    .new_fiq_bit  (wr_data[6]),
    .mode_ok      (mode_ok),
    .mask         (cur_mask),
    .mode_drop    (mode_drop)
  );

  psr_saved_mask #(.LANES(SEL_W)) u_smask (
    .byte_sel (byte_sel),
    .mask     (sv_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= RESET_WORD;
      saved_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= wr_en & mode_drop;
      if (wr_en)    status_q <= (status_q & ~cur_mask) | (wr_data & cur_mask);
      if (sv_wr_en) saved_q  <= (saved_q & ~sv_mask) | (wr_data & sv_mask);
    end
  end

  assign status_o  = status_q;
  assign saved_o   = saved_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/psr_wmask_chk.sv
module psr_wmask_chk
  import psr_wmask_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        sv_wr_en,
  input logic [31:0] wr_data,
  input logic        nmfi,
  input logic [31:0] status_o,
  input logic [31:0] saved_o,
  input logic        illegal_o
);
  AST_RESET_VALUE: assert property (@(posedge clk)
    rst |=> (status_o == RESET_WORD && saved_o == 32'h0 && !illegal_o)); // R1

  AST_RSVD_STABLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> status_o[23:20] == $past(status_o[23:20])); // R2

  AST_USER_MODE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && status_o[4:0] == M_USR) |=> status_o[4:0] == M_USR); // R5

  AST_NMFI_NO_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && nmfi && !status_o[6] && wr_data[6]) |=> !status_o[6]); // R6

  AST_FLAG_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> $past(wr_en)); // R9

  AST_MODE_ALWAYS_KNOWN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> mode_known(status_o[4:0])); // R10

  AST_SAVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sv_wr_en |=> $stable(saved_o)); // R11

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(status_o) && !illegal_o)); // R12
endmodule

bind psr_wmask_unit psr_wmask_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .sv_wr_en  (sv_wr_en),
  .wr_data   (wr_data),
  .nmfi      (nmfi),
  .status_o  (status_o),
  .saved_o   (saved_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_psr_wmask_unit.sv
`timescale 1ns/1ps
module sim_psr_wmask_unit;
  logic        clk = 1'b0;
  logic        rst, wr_en, sv_wr_en;
  logic [31:0] wr_data;
  logic [3:0]  byte_sel;
  logic        affect_state, sec_state, aw_permit, fw_permit;
  logic        fiq_restrict, ns_bit, virt_present, nmfi;
  logic [31:0] status_o, saved_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_st, exp_sv;
  logic        exp_fl;

  always #4 clk = ~clk;

  psr_wmask_unit u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sv_wr_en(sv_wr_en),
    .wr_data(wr_data), .byte_sel(byte_sel), .affect_state(affect_state),
    .sec_state(sec_state), .aw_permit(aw_permit), .fw_permit(fw_permit),
    .fiq_restrict(fiq_restrict), .ns_bit(ns_bit), .virt_present(virt_present),
    .nmfi(nmfi), .status_o(status_o), .saved_o(saved_o), .illegal_o(illegal_o)
  );

  function automatic logic listed(input logic [4:0] m);
    return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1F};
  endfunction

  // expected {drop, new status} built from the requirement text
  function automatic logic [32:0] expect_write(input logic [31:0] cur, input logic [31:0] d,
      input logic [3:0] bs, input logic aff, input logic [6:0] ctl);
    logic sec, aw, fw, fr, ns, vp, nm, priv, ok, drop;
    logic [31:0] m;
    {sec, aw, fw, fr, ns, vp, nm} = ctl;
    priv = (cur[4:0] != 5'h10);
    m = 32'h0;
    drop = 1'b0;
    if (bs[3]) m = m | (aff ? 32'hFF00_0000 : 32'hF800_0000);
    if (bs[2]) m = m | 32'h000F_0000;
    if (bs[1]) begin
      m = m | 32'h0000_0200;
      if (aff) m = m | 32'h0000_FC00;
      if (priv && (sec || aw || vp)) m = m | 32'h0000_0100;
    end
    if (bs[0]) begin
      if (aff) m = m | 32'h20;
      if (priv) begin
        m = m | 32'h80;
        if ((!nm || !d[6]) && (sec || fw || vp)) m = m | 32'h40;
        ok = listed(d[4:0]) && !(!sec && d[4:0] == 5'h16)
             && !(!sec && fr && d[4:0] == 5'h11) && !(!ns && d[4:0] == 5'h1A);
        if (ok) m = m | 32'h1F;
        else    drop = 1'b1;
      end
    end
    return {drop, (cur & ~m) | (d & m)};
  endfunction

  function automatic logic [31:0] expect_saved(input logic [31:0] cur, input logic [31:0] d,
      input logic [3:0] bs);
    logic [31:0] m;
    m = {{8{bs[3]}}, 4'h0, {4{bs[2]}}, {8{bs[1]}}, {8{bs[0]}}};
    return (cur & ~m) | (d & m);
  endfunction

  function automatic string tag_of_bit(input int b);
    if (b >= 16) return "R2";
    if (b >= 9)  return "R3";
    if (b == 8)  return "R4";
    if (b == 7)  return "R5";
    if (b == 6)  return "R6";
    if (b == 5)  return "R7";
    return "R8";
  endfunction

  task automatic check_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_status(input string ovr);
    string t;
    t = ovr;
    if (t == "") begin
      t = "R8";
      for (int b = 31; b >= 0; b--)
        if (status_o[b] !== exp_st[b]) begin t = tag_of_bit(b); break; end
    end
    check_word(t, status_o, exp_st);
  endtask

  task automatic set_ctl(input logic [6:0] ctl);
    {sec_state, aw_permit, fw_permit, fiq_restrict, ns_bit, virt_present, nmfi} = ctl;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; sv_wr_en = 1'b0;
    @(negedge clk);
    exp_st = 32'h0000_01D3; exp_sv = 32'h0; exp_fl = 1'b0;
    check_word("R1", status_o, exp_st);
    check_word("R1", saved_o, exp_sv);
    check_word("R1", {31'h0, illegal_o}, {31'h0, exp_fl});
    rst = 1'b0;
  endtask

  // one strobed write; checks after the registering edge
  task automatic do_write(input logic [31:0] d, input logic [3:0] bs, input logic aff,
      input logic [6:0] ctl, input logic sv, input string ftag);
    logic [32:0] r;
    wr_en = 1'b1; sv_wr_en = sv; wr_data = d; byte_sel = bs; affect_state = aff;
    set_ctl(ctl);
    r = expect_write(exp_st, d, bs, aff, ctl);
    exp_st = r[31:0];
    exp_fl = r[32];
    if (sv) exp_sv = expect_saved(exp_sv, d, bs);
    @(negedge clk);
    check_status("");
    check_word(ftag, {31'h0, illegal_o}, {31'h0, exp_fl});
    if (sv) check_word("R11", saved_o, exp_sv);
  endtask

  initial begin
    #(8 * 199000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0]  targets [12];
    logic [4:0]  starts [4];
    logic [31:0] d;
    int n;
    targets = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h16, 5'h17,
                5'h1A, 5'h1B, 5'h1F, 5'h00, 5'h14, 5'h05};
    starts  = '{5'h10, 5'h11, 5'h13, 5'h1A};
    rst = 1'b1; wr_en = 1'b0; sv_wr_en = 1'b0; wr_data = '0; byte_sel = '0;
    affect_state = 1'b0;
    set_ctl(7'h0);
    n = 0;
    for (int s = 0; s < 4; s++) begin
      for (int ctl = 0; ctl < 128; ctl++) begin
        for (int bs = 0; bs < 16; bs++) begin
          for (int aff = 0; aff < 2; aff++) begin
            n++;
            do_reset();
            // load a starting word from supervisor with every permit open
            d = (n * 32'h9E37_79B1) ^ 32'hA5C3_0F69;
            d[4:0] = starts[s];
            do_write(d, 4'hF, 1'b1, 7'b1111100, 1'b1, "R9");
            // the write under test
            d = (n * 32'h6C07_8965) ^ 32'h3B1D_E247;
            d[4:0] = targets[n % 12];
            do_write(d, 4'(bs), 1'(aff), 7'(ctl), 1'b1,
                     listed(targets[n % 12]) ? "R9" : "R10");
            // strobe low: nothing may change, flag clears
            wr_en = 1'b0; sv_wr_en = 1'b0; wr_data = ~d; byte_sel = 4'hF;
            @(negedge clk);
            check_word("R12", status_o, exp_st);
            check_word("R12", {31'h0, illegal_o}, 32'h0);
            check_word("R11", saved_o, exp_sv);
          end
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule